// File: doc/BRIEF.md
# Flash Block Lock Register Bank

This block is the protection register bank that sits beside a sixteen-block flash array and answers a register window at the top of the address space. Each array block owns a small lock register with three active bits: one that blocks program and erase, one that hides the block's contents from array reads, and one that freezes the register itself until the next reset. Software reaches these registers, and a read-only register of sampled general-purpose input pins, through a single-cycle request/acknowledge register port.

Toward the array controller the block produces a registered write-permit bit and a read-mask bit for every array block. Write permission also depends on three board pins: a programming-voltage lockout that covers every block, an active-low top-block lock that covers the highest block, and an active-low write-protect that covers all other blocks. The block also flags a program or erase attempt on a protected block and zeroes array read data from read-locked blocks, one cycle after the request in both cases.

Top module: `flash_lock_bank`

## Requirements
- R1: On synchronous reset every lock register reads 01h (write-locked, not read-locked, not frozen), `wr_permit` is all zero and `rd_mask` is all zero.
- R2: The lock register of block N answers at address FFB00002h + N x 10000h. Bit 0 is the write lock, bit 1 the lock-down, bit 2 the read lock. Bits 7:3 read as zero and ignore writes. `reg_ack` is high in the cycle after each `reg_req`, and read data is valid with it.
- R3: While a register's lock-down bit is 1, writes to that register leave it unchanged. Only a reset clears it.
- R4: A `prog_req` to a block whose write permission is denied gives `prog_fail` high in the next cycle. A request to a permitted block leaves `prog_fail` low.
- R5: When a block's read-lock bit is 1, its `rd_mask` bit is 1, and array data passed through `ard_data_in` for that block comes out of `ard_data_out` as 00h one cycle later. Other blocks pass data through unchanged.
- R6: While `vpp_low` is 1, every bit of `wr_permit` is 0, whatever the lock bits hold.
- R7: While `tbl_n` is 0, the highest block is not write-permitted. While `wp_n` is 0, blocks 0 to NUM_BLOCKS-2 are not write-permitted. Neither pin affects the other range.
- R8: `wr_permit[N]` is 1 exactly when block N's write lock is 0, `vpp_low` is 0 and the pin for its range is 1. It is registered, so it follows a change one cycle later.
- R9: A read at FFBC0100h returns the `gpi_pins` values after two synchronizer flops and one capture flop, zero-extended to 8 bits. Writes there change nothing.
- R10: An access to any other address reads 00h, changes no register, and raises `reg_addr_err` together with its acknowledge for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_req | input | 1 | Register access request, one cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_ack | output | 1 | Acknowledge, one cycle after request |
| reg_rdata | output | 8 | Read data, valid with acknowledge |
| reg_addr_err | output | 1 | Access hit no decoded register |
| vpp_low | input | 1 | Programming voltage below lockout, protects all blocks |
| tbl_n | input | 1 | Active-low protect for the highest block |
| wp_n | input | 1 | Active-low protect for all lower blocks |
| gpi_pins | input | GPI_W | Asynchronous general-purpose inputs |
| prog_req | input | 1 | Program or erase attempt |
| prog_blk | input | IDX_W | Block targeted by the attempt |
| prog_fail | output | 1 | Attempt refused, one cycle later |
| ard_valid_in | input | 1 | Array read data valid |
| ard_blk | input | IDX_W | Block the array data came from |
| ard_data_in | input | 8 | Raw array read data |
| ard_valid_out | output | 1 | Masked read data valid |
| ard_data_out | output | 8 | Read data, zeroed for read-locked blocks |
| wr_permit | output | NUM_BLOCKS | Per-block write permission |
| rd_mask | output | NUM_BLOCKS | Per-block read-lock indication |

## Verification
The bench builds the block with its defaults: sixteen blocks, a 16-bit address stride and five input pins. With sixteen blocks every value of the block-index address field decodes to a register. The highest block is the only one under the top-block pin, so the split between the two pin ranges is reached at its real boundary. Addresses one step off the stride, just past the last block and below the base still take the address-error path.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;

  // Field order fixes the register layout: bit2 read lock, bit1 lock-down, bit0 write lock.
  typedef struct packed {
    logic rd_lock;
    logic lock_down;
    logic wr_lock;
  } lock_t;

  localparam lock_t LOCK_RST = '{rd_lock: 1'b0, lock_down: 1'b0, wr_lock: 1'b1};

  function automatic logic [7:0] lock_to_byte(input lock_t l);
    return {5'b00000, l};
  endfunction

  function automatic lock_t byte_to_lock(input logic [7:0] b);
    return lock_t'(b[2:0]);
  endfunction

endpackage

// File: rtl/gpi_sync.sv
module gpi_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins,
  output logic [W-1:0] captured
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= '0;
      sync_q   <= '0;
      captured <= '0;
    end else begin
      meta_q   <= pins;
      sync_q   <= meta_q;
      captured <= sync_q;
    end
  end
endmodule

// File: rtl/lock_regfile.sv
module lock_regfile
  import flash_lock_pkg::*;
#(
  parameter int          NUM_BLOCKS = 16,
  parameter int          ADDR_W     = 32,
  parameter int          STRIDE_SH  = 16,
  parameter logic [31:0] LOCK_BASE  = 32'hFFB0_0002,
  parameter logic [31:0] GPI_ADDR   = 32'hFFBC_0100,
  parameter int          GPI_W      = 5,
  localparam int         IDX_W      = $clog2(NUM_BLOCKS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req,
  input  logic                   wr,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             wdata,
  input  logic [GPI_W-1:0]       gpi_val,
  output logic                   ack,
  output logic [7:0]             rdata,
  output logic                   addr_err,
  output lock_t [NUM_BLOCKS-1:0] lock_q
);
  logic [ADDR_W-1:0] offset, idx_full;
  logic [IDX_W-1:0]  idx;
  logic              lock_hit, gpi_hit;

  always_comb begin
    offset   = addr - ADDR_W'(LOCK_BASE);
    idx_full = offset >> STRIDE_SH;
    idx      = idx_full[IDX_W-1:0];
    lock_hit = (offset[STRIDE_SH-1:0] == '0) && (idx_full < ADDR_W'(NUM_BLOCKS));
    gpi_hit  = (addr == ADDR_W'(GPI_ADDR));
  end

  for (genvar gi = 0; gi < NUM_BLOCKS; gi++) begin : g_lock
    always_ff @(posedge clk) begin
      if (rst)
        lock_q[gi] <= LOCK_RST;
      else if (req && wr && lock_hit && (idx == IDX_W'(gi)) && !lock_q[gi].lock_down)
        lock_q[gi] <= byte_to_lock(wdata);
    end

    // R3: a frozen register holds its value until reset
    p_lockdown_hold_r3: assert property (@(posedge clk) disable iff (rst)
      lock_q[gi].lock_down |=> $stable(lock_q[gi]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack      <= 1'b0;
      addr_err <= 1'b0;
      rdata    <= 8'h00;
    end else begin
      ack      <= req;
      addr_err <= req && !lock_hit && !gpi_hit;
      if (req && !wr && lock_hit)
        rdata <= lock_to_byte(lock_q[idx]);
      else if (req && !wr && gpi_hit)
        rdata <= 8'(gpi_val);
      else
        rdata <= 8'h00;
    end
  end

  p_ack_next_r2: assert property (@(posedge clk) disable iff (rst)
    req |=> ack);
  p_err_with_ack_r10: assert property (@(posedge clk) disable iff (rst)
    addr_err |-> ack);
  p_err_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
    addr_err |-> (rdata == 8'h00));
endmodule

// File: rtl/lock_policy.sv
module lock_policy
  import flash_lock_pkg::*;
#(
  parameter int  NUM_BLOCKS = 16,
  localparam int IDX_W      = $clog2(NUM_BLOCKS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  lock_t [NUM_BLOCKS-1:0] lock_q,
  input  logic                   vpp_low,
  input  logic                   tbl_n,
  input  logic                   wp_n,
  input  logic                   prog_req,
  input  logic [IDX_W-1:0]       prog_blk,
  input  logic                   ard_valid_in,
  input  logic [IDX_W-1:0]       ard_blk,
  input  logic [7:0]             ard_data_in,
  output logic [NUM_BLOCKS-1:0]  wr_permit,
  output logic [NUM_BLOCKS-1:0]  rd_mask,
  output logic                   prog_fail,
  output logic                   ard_valid_out,
  output logic [7:0]             ard_data_out
);
  logic [NUM_BLOCKS-1:0] permit_now, rlock_now;

  for (genvar gi = 0; gi < NUM_BLOCKS; gi++) begin : g_blk
    if (gi == NUM_BLOCKS - 1) begin : g_top
      assign permit_now[gi] = ~lock_q[gi].wr_lock & ~vpp_low & tbl_n;
    end else begin : g_main
      assign permit_now[gi] = ~lock_q[gi].wr_lock & ~vpp_low & wp_n;
    end
    assign rlock_now[gi] = lock_q[gi].rd_lock;
  end

  logic prog_ok, ard_hide;
  always_comb begin
    prog_ok  = (32'(prog_blk) < NUM_BLOCKS) && permit_now[prog_blk];
    ard_hide = (32'(ard_blk) >= NUM_BLOCKS) || rlock_now[ard_blk];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_permit     <= '0;
      rd_mask       <= '0;
      prog_fail     <= 1'b0;
      ard_valid_out <= 1'b0;
      ard_data_out  <= 8'h00;
    end else begin
      wr_permit     <= permit_now;
      rd_mask       <= rlock_now;
      prog_fail     <= prog_req && !prog_ok;
      ard_valid_out <= ard_valid_in;
      ard_data_out  <= (ard_valid_in && !ard_hide) ? ard_data_in : 8'h00;
    end
  end

  p_vpp_all_r6: assert property (@(posedge clk) disable iff (rst)
    vpp_low |=> (wr_permit == '0));
  p_top_pin_r7: assert property (@(posedge clk) disable iff (rst)
    !tbl_n |=> !wr_permit[NUM_BLOCKS-1]);
  p_prog_fail_r4: assert property (@(posedge clk) disable iff (rst)
    (prog_req && lock_q[prog_blk].wr_lock) |=> prog_fail);
  p_rd_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (ard_valid_in && lock_q[ard_blk].rd_lock) |=> (ard_data_out == 8'h00));
endmodule

// File: rtl/flash_lock_bank.sv
module flash_lock_bank
  import flash_lock_pkg::*;
#(
  parameter int          NUM_BLOCKS = 16,
  parameter int          ADDR_W     = 32,
  parameter int          STRIDE_SH  = 16,
  parameter logic [31:0] LOCK_BASE  = 32'hFFB0_0002,
  parameter logic [31:0] GPI_ADDR   = 32'hFFBC_0100,
  parameter int          GPI_W      = 5,
  localparam int         IDX_W      = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_req,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [7:0]            reg_wdata,
  output logic                  reg_ack,
  output logic [7:0]            reg_rdata,
  output logic                  reg_addr_err,
  input  logic                  vpp_low,
  input  logic                  tbl_n,
  input  logic                  wp_n,
  input  logic [GPI_W-1:0]      gpi_pins,
  input  logic                  prog_req,
  input  logic [IDX_W-1:0]      prog_blk,
  output logic                  prog_fail,
  input  logic                  ard_valid_in,
  input  logic [IDX_W-1:0]      ard_blk,
  input  logic [7:0]            ard_data_in,
  output logic                  ard_valid_out,
  output logic [7:0]            ard_data_out,
  output logic [NUM_BLOCKS-1:0] wr_permit,
  output logic [NUM_BLOCKS-1:0] rd_mask
);
  lock_t [NUM_BLOCKS-1:0] lock_q;
  logic  [GPI_W-1:0]      gpi_val;

  gpi_sync #(.W(GPI_W)) u_gpi (
    .clk      (clk),
    .rst      (rst),
    .pins     (gpi_pins),
    .captured (gpi_val)
  );

  lock_regfile #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .ADDR_W     (ADDR_W),
    .STRIDE_SH  (STRIDE_SH),
    .LOCK_BASE  (LOCK_BASE),
    .GPI_ADDR   (GPI_ADDR),
    .GPI_W      (GPI_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .req      (reg_req),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .gpi_val  (gpi_val),
    .ack      (reg_ack),
    .rdata    (reg_rdata),
    .addr_err (reg_addr_err),
    .lock_q   (lock_q)
  );

  lock_policy #(.NUM_BLOCKS(NUM_BLOCKS)) u_policy (
    .clk           (clk),
    .rst           (rst),
    .lock_q        (lock_q),
    .vpp_low       (vpp_low),
    .tbl_n         (tbl_n),
    .wp_n          (wp_n),
    .prog_req      (prog_req),
    .prog_blk      (prog_blk),
    .ard_valid_in  (ard_valid_in),
    .ard_blk       (ard_blk),
    .ard_data_in   (ard_data_in),
    .wr_permit     (wr_permit),
    .rd_mask       (rd_mask),
    .prog_fail     (prog_fail),
    .ard_valid_out (ard_valid_out),
    .ard_data_out  (ard_data_out)
  );
endmodule

// File: tb/sim_flash_lock_bank.sv
module sim_flash_lock_bank;
  localparam int NB   = 16;
  localparam int GW   = 5;
  localparam int IW   = 4;
  localparam logic [31:0] GPI_A = 32'hFFBC_0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_req = 0, reg_wr = 0;
  logic [31:0] reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic reg_ack, reg_addr_err;
  logic [7:0] reg_rdata;
  logic vpp_low = 0, tbl_n = 1, wp_n = 1;
  logic [GW-1:0] gpi_pins = '0;
  logic prog_req = 0;
  logic [IW-1:0] prog_blk = '0;
  logic prog_fail;
  logic ard_valid_in = 0;
  logic [IW-1:0] ard_blk = '0;
  logic [7:0] ard_data_in = '0;
  logic ard_valid_out;
  logic [7:0] ard_data_out;
  logic [NB-1:0] wr_permit, rd_mask;

  always #5 clk = ~clk;

  flash_lock_bank u0 (.*);

  int vec = 0, bad = 0;
  bit done = 0;
  logic [2:0] m [NB];

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] blk_addr(input int b);
    return 32'hFFB0_0002 + 32'(b) * 32'h1_0000;
  endfunction

  function automatic int decode(input logic [31:0] a); // -1 none, NB = gpi
    if (a == GPI_A) return NB;
    if (a[31:20] == 12'hFFB && a[15:0] == 16'h0002) return int'(a[19:16]);
    return -1;
  endfunction

  function automatic logic [NB-1:0] exp_perm();
    logic [NB-1:0] p;
    for (int b = 0; b < NB; b++)
      p[b] = !m[b][0] && !vpp_low && ((b == NB-1) ? tbl_n : wp_n);
    return p;
  endfunction

  function automatic logic [NB-1:0] exp_mask();
    logic [NB-1:0] p;
    for (int b = 0; b < NB; b++) p[b] = m[b][2];
    return p;
  endfunction

  task automatic model_reset();
    for (int b = 0; b < NB; b++) m[b] = 3'b001;
  endtask

  // Starts and ends at a falling edge.
  task automatic access(input bit w, input logic [31:0] a, input logic [7:0] d, input string r);
    int k;
    logic [7:0] exp_rd;
    k = decode(a);
    exp_rd = 8'h00;
    if (!w && k >= 0 && k < NB) exp_rd = {5'b0, m[k]};
    if (!w && k == NB) exp_rd = 8'(gpi_pins);
    if (w && k >= 0 && k < NB && !m[k][1]) m[k] = d[2:0];
    reg_req = 1; reg_wr = w; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 0; reg_wr = 0;
    chk({r, " R2 ack"}, 32'(reg_ack), 1);
    chk({r, " R10 err"}, 32'(reg_addr_err), 32'(k < 0));
    if (!w) chk({r, " rdata"}, 32'(reg_rdata), 32'(exp_rd));
  endtask

  task automatic chk_outputs(input string r);
    @(negedge clk);
    chk({r, " R8 wr_permit"}, 32'(wr_permit), 32'(exp_perm()));
    chk({r, " R5 rd_mask"}, 32'(rd_mask), 32'(exp_mask()));
  endtask

  task automatic prog(input int b, input string r);
    prog_req = 1; prog_blk = IW'(b);
    @(negedge clk);
    prog_req = 0;
    chk({r, " R4 prog_fail"}, 32'(prog_fail), 32'(!exp_perm()[b]));
  endtask

  task automatic aread(input int b, input logic [7:0] d, input string r);
    ard_valid_in = 1; ard_blk = IW'(b); ard_data_in = d;
    @(negedge clk);
    ard_valid_in = 0;
    chk({r, " R5 valid"}, 32'(ard_valid_out), 1);
    chk({r, " R5 data"}, 32'(ard_data_out), 32'(m[b][2] ? 8'h00 : d));
  endtask

  task automatic read_all(input string r);
    for (int b = 0; b < NB; b++) access(0, blk_addr(b), 8'h00, r);
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 wr_permit after reset", 32'(wr_permit), 0);
    chk("R1 rd_mask after reset", 32'(rd_mask), 0);
    read_all("R1 reset value");

    access(1, blk_addr(3), 8'h00, "R2 clear block3");
    access(0, blk_addr(3), 8'h00, "R2 read block3");
    chk_outputs("R8 block3 open");

    access(1, blk_addr(7), 8'hFC, "R2 upper bits");
    access(0, blk_addr(7), 8'h00, "R2 upper bits read");
    chk_outputs("R5 block7 read lock");
    aread(7, 8'hA5, "R5 locked");
    aread(3, 8'hA5, "R5 open");

    access(1, blk_addr(15), 8'h00, "R7 open top");
    tbl_n = 0; chk_outputs("R7 top pin low");
    tbl_n = 1; wp_n = 0; chk_outputs("R7 wp pin low");
    prog(15, "R7 top ok"); prog(3, "R7 main blocked");
    wp_n = 1;
    vpp_low = 1; chk_outputs("R6 vpp low");
    prog(3, "R6 vpp prog"); prog(15, "R6 vpp top");
    vpp_low = 0; chk_outputs("R6 vpp release");
    prog(0, "R4 locked block0"); prog(3, "R4 open block3");

    access(1, blk_addr(5), 8'h02, "R3 set lockdown");
    access(1, blk_addr(5), 8'h05, "R3 write frozen");
    access(0, blk_addr(5), 8'h00, "R3 readback");
    chk_outputs("R3 permit frozen");

    gpi_pins = 5'h15;
    repeat (4) @(negedge clk);
    access(0, GPI_A, 8'h00, "R9 gpi read");
    access(1, GPI_A, 8'hFF, "R9 gpi write");
    access(0, GPI_A, 8'h00, "R9 gpi after write");

    access(0, 32'hFFB0_0003, 8'h00, "R10 off stride");
    access(1, 32'hFFB0_0102, 8'h00, "R10 wr off stride");
    access(1, 32'hFFC0_0002, 8'h00, "R10 wr past last");
    access(1, 32'h0000_0000, 8'h00, "R10 wr low");
    access(0, 32'hFFAF_0002, 8'h00, "R10 below base");
    read_all("R10 regs unchanged");

    do_reset();
    access(0, blk_addr(5), 8'h00, "R3 R1 reset clears lockdown");
    chk_outputs("R1 after mid reset");

    for (int it = 0; it < 400; it++) begin
      int op, b;
      op = int'($urandom_range(0, 9));
      b  = int'($urandom_range(0, NB-1));
      if (op < 3) begin
        logic [7:0] d;
        d = 8'($urandom());
        if ($urandom_range(0, 7) != 0) d[1] = 1'b0;
        access(1, blk_addr(b), d, "R2 rnd write");
        access(0, blk_addr(b), 8'h00, "R3 rnd read");
      end else if (op == 3) begin
        vpp_low = ($urandom_range(0, 3) == 0);
        tbl_n = 1'($urandom()); wp_n = 1'($urandom());
        chk_outputs("R7 rnd pins");
      end else if (op == 4) prog(b, "R4 rnd prog");
      else if (op == 5) aread(b, 8'($urandom()), "R5 rnd aread");
      else if (op == 6) begin
        logic [31:0] a;
        a = blk_addr(b) ^ (32'h1 << $urandom_range(0, 31));
        access(0, a, 8'h00, "R10 rnd addr");
      end else if (op == 7) chk_outputs("R8 rnd");
      else if (op == 8) begin
        gpi_pins = GW'($urandom());
        repeat (4) @(negedge clk);
        access(0, GPI_A, 8'h00, "R9 rnd gpi");
      end else if ($urandom_range(0, 15) == 0) begin
        do_reset();
        read_all("R1 rnd reset");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      vec++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule